// File: doc/BRIEF.md
# Backtracking Context Stack Bank

This block holds the working search context of a recursive decision-tree search and saves or restores that whole context at branching points. The context has five parts: a row-removal mask, a column-removal mask, a vector of per-row estimate fields (the count of ones still left in each row), a mask of candidate branches already tried at the current branching point, and the partial result (the set of columns chosen so far). In each mask a 0 bit marks a row or column that is still active and a 1 bit marks one that has been removed.

The controlling search logic changes the working registers freely through parallel loads. It issues a single push when it reaches a branching point and a single pop when it backtracks. A push stores all five parts as one frame. A pop brings all five back in the same clock edge. Because a zero estimate always coincides with a removed row, the row mask can be left out of the frame and rebuilt from the restored estimates. A parameter selects this shared layout or a full layout that keeps the row mask in the frame. Illegal commands raise a one-cycle fault and leave the stack untouched.

Top module: `ctx_stack_bank`

## Requirements
- R1: After a synchronous active-high reset, all five working registers read zero, the level reads 0, the empty flag is 1, and the full and fault flags are 0.
- R2: A load strobe with no pop request writes its data into that working register, visible on the next cycle. Registers without a strobe keep their values.
- R3: An accepted push stores the working register values present before that clock edge and raises the level by one. Loads given in the same cycle as the push still update the working registers.
- R4: An accepted pop restores the column mask, estimate vector, branch mask and partial result of the most recent unpopped frame in last-in first-out order, all on the same edge, and lowers the level by one. Every load strobe is ignored in any cycle where pop is requested.
- R5: In the shared layout (the default), the restored row-mask bit of row k is 1 exactly when estimate field k (bits k*CNT_W up to k*CNT_W+CNT_W-1) of the restored vector is zero.
- R6: The empty flag is 1 exactly when the level is 0, and the full flag is 1 exactly when the level equals DEPTH.
- R7: A pop at level 0, a push at level DEPTH, or push and pop requested together sets the fault flag for the next cycle. It leaves the level and the stored frames unchanged, and leaves the working registers unchanged except for loads allowed under R2 and R3.
- R8: The fault flag is 0 in the cycle after any cycle that carries no illegal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Save the working context as a new frame |
| pop_i | input | 1 | Restore the newest frame into the working registers |
| ld_row_i | input | 1 | Load strobe for the row mask |
| row_i | input | N_ROWS | Row mask load data, 1 = removed |
| ld_col_i | input | 1 | Load strobe for the column mask |
| col_i | input | N_COLS | Column mask load data, 1 = removed |
| ld_est_i | input | 1 | Load strobe for the estimate vector |
| est_i | input | N_ROWS*CNT_W | Estimate vector load data, field k for row k |
| ld_br_i | input | 1 | Load strobe for the tried-branch mask |
| br_i | input | N_COLS | Tried-branch mask load data |
| ld_res_i | input | 1 | Load strobe for the partial result |
| res_i | input | N_COLS | Partial result load data, 1 = column chosen |
| row_o | output | N_ROWS | Working row mask |
| col_o | output | N_COLS | Working column mask |
| est_o | output | N_ROWS*CNT_W | Working estimate vector |
| br_o | output | N_COLS | Working tried-branch mask |
| res_o | output | N_COLS | Working partial result |
| level_o | output | $clog2(DEPTH+1) | Number of stored frames |
| empty_o | output | 1 | No frame stored |
| full_o | output | 1 | DEPTH frames stored |
| fault_o | output | 1 | Illegal command seen on the previous cycle |

## Verification
A corrupted level counter or write address shows up as a wrong level or flag on the next cycle. Its effect on restored frames may stay hidden until the pop that reaches the damaged slot. For that reason every frame is filled with distinct patterns and the stack is drained completely, which exposes misplaced or overwritten slots within DEPTH cycles. A wrong frame slice or a wrong row-rebuild rule appears on the register outputs one cycle after the pop. A load that leaks into a pop cycle appears in that same cycle as well.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_PUSH  = 2'd1,
        CMD_POP   = 2'd2,
        CMD_CLASH = 2'd3
    } ctx_cmd_e;

    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic bad;
    } ctx_grant_s;

    function automatic ctx_cmd_e decode_cmd(input logic push, input logic pop);
        return ctx_cmd_e'({pop, push});
    endfunction

endpackage

// File: rtl/ctx_depth_ctrl.sv
module ctx_depth_ctrl
    import ctx_stack_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    output ctx_grant_s        grant_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    logic [LVL_W-1:0] level_q;
    logic             fault_q;
    ctx_cmd_e         cmd;
    ctx_grant_s       grant;
    logic             is_empty;
    logic             is_full;

    always_comb begin
        cmd           = decode_cmd(push_i, pop_i);
        is_empty      = (level_q == '0);
        is_full       = (level_q == LVL_W'(DEPTH));
        grant.push_ok = (cmd == CMD_PUSH) && !is_full;
        grant.pop_ok  = (cmd == CMD_POP) && !is_empty;
        grant.bad     = ((cmd == CMD_PUSH) && is_full)
                      || ((cmd == CMD_POP) && is_empty)
                      || (cmd == CMD_CLASH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= grant.bad;
            if (grant.push_ok) begin
                level_q <= level_q + 1'b1;
            end else if (grant.pop_ok) begin
                level_q <= level_q - 1'b1;
            end
        end
    end

    assign grant_o   = grant;
    assign level_o   = level_q;
    assign empty_o   = is_empty;
    assign full_o    = is_full;
    assign fault_o   = fault_q;
    assign wr_addr_o = ADDR_W'(level_q);
    assign rd_addr_o = ADDR_W'(level_q) - ADDR_W'(1);

    // R6: the level never leaves the range 0..DEPTH
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        level_q <= LVL_W'(DEPTH));

    assert_push_step_R3: assert property (@(posedge clk) disable iff (rst)
        grant.push_ok |=> level_q == $past(level_q) + 1'b1);

    assert_pop_step_R4: assert property (@(posedge clk) disable iff (rst)
        grant.pop_ok |=> level_q == $past(level_q) - 1'b1);

    assert_reject_hold_R7: assert property (@(posedge clk) disable iff (rst)
        grant.bad |=> $stable(level_q) && fault_q);

endmodule

// File: rtl/ctx_frame_store.sv
module ctx_frame_store #(
    parameter int DEPTH   = 16,
    parameter int FRAME_W = 64,
    parameter int ADDR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  waddr_i,
    input  logic [FRAME_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]  raddr_i,
    output logic [FRAME_W-1:0] rdata_o
);

    logic [FRAME_W-1:0] slot_view [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [FRAME_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == ADDR_W'(gi))) begin
                q <= wdata_i;
            end
        end
        assign slot_view[gi] = q;
    end

    assign rdata_o = slot_view[raddr_i];

endmodule

// File: rtl/ctx_work_reg.sv
module ctx_work_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] ld_d_i,
    input  logic         rest_i,
    input  logic [W-1:0] rest_d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (rest_i) begin
            q_o <= rest_d_i;
        end else if (ld_i) begin
            q_o <= ld_d_i;
        end
    end

endmodule

// File: rtl/ctx_stack_bank.sv
module ctx_stack_bank
    import ctx_stack_pkg::*;
#(
    parameter int N_ROWS         = 10,
    parameter int N_COLS         = 9,
    parameter int CNT_W          = 4,
    parameter int DEPTH          = 16,
    parameter bit SHARE_ROW_SLOT = 1'b1,
    localparam int EST_W  = N_ROWS * CNT_W,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              ld_row_i,
    input  logic [N_ROWS-1:0] row_i,
    input  logic              ld_col_i,
    input  logic [N_COLS-1:0] col_i,
    input  logic              ld_est_i,
    input  logic [EST_W-1:0]  est_i,
    input  logic              ld_br_i,
    input  logic [N_COLS-1:0] br_i,
    input  logic              ld_res_i,
    input  logic [N_COLS-1:0] res_i,
    output logic [N_ROWS-1:0] row_o,
    output logic [N_COLS-1:0] col_o,
    output logic [EST_W-1:0]  est_o,
    output logic [N_COLS-1:0] br_o,
    output logic [N_COLS-1:0] res_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              fault_o
);

    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int BASE_W  = EST_W + 3 * N_COLS;
    localparam int FRAME_W = BASE_W + (SHARE_ROW_SLOT ? 0 : N_ROWS);

    ctx_grant_s         grant;
    logic [ADDR_W-1:0]  wr_addr;
    logic [ADDR_W-1:0]  rd_addr;
    logic [FRAME_W-1:0] push_frame;
    logic [FRAME_W-1:0] pop_frame;
    logic [N_ROWS-1:0]  pop_row;
    logic [N_COLS-1:0]  pop_col;
    logic [EST_W-1:0]   pop_est;
    logic [N_COLS-1:0]  pop_br;
    logic [N_COLS-1:0]  pop_res;
    logic               ld_gate;

    assign ld_gate = !pop_i;

    ctx_depth_ctrl #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W),
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .grant_o  (grant),
        .level_o  (level_o),
        .empty_o  (empty_o),
        .full_o   (full_o),
        .fault_o  (fault_o),
        .wr_addr_o(wr_addr),
        .rd_addr_o(rd_addr)
    );

    ctx_frame_store #(
        .DEPTH  (DEPTH),
        .FRAME_W(FRAME_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk    (clk),
        .we_i   (grant.push_ok),
        .waddr_i(wr_addr),
        .wdata_i(push_frame),
        .raddr_i(rd_addr),
        .rdata_o(pop_frame)
    );

    assign pop_est = pop_frame[EST_W-1:0];
    assign pop_col = pop_frame[EST_W +: N_COLS];
    assign pop_br  = pop_frame[EST_W + N_COLS +: N_COLS];
    assign pop_res = pop_frame[EST_W + 2 * N_COLS +: N_COLS];

    if (SHARE_ROW_SLOT) begin : g_shared
        assign push_frame = {res_o, br_o, col_o, est_o};
        for (genvar gr = 0; gr < N_ROWS; gr++) begin : g_rebuild
            assign pop_row[gr] = (pop_est[gr * CNT_W +: CNT_W] == '0);

            assert_row_from_est_R5: assert property (@(posedge clk) disable iff (rst)
                grant.pop_ok |=> row_o[gr] == (est_o[gr * CNT_W +: CNT_W] == '0));
        end
    end else begin : g_full
        assign push_frame = {row_o, res_o, br_o, col_o, est_o};
        assign pop_row    = pop_frame[BASE_W +: N_ROWS];
    end

    ctx_work_reg #(.W(N_ROWS)) u_row (
        .clk(clk), .rst(rst), .ld_i(ld_row_i && ld_gate), .ld_d_i(row_i),
        .rest_i(grant.pop_ok), .rest_d_i(pop_row), .q_o(row_o)
    );

    ctx_work_reg #(.W(N_COLS)) u_col (
        .clk(clk), .rst(rst), .ld_i(ld_col_i && ld_gate), .ld_d_i(col_i),
        .rest_i(grant.pop_ok), .rest_d_i(pop_col), .q_o(col_o)
    );

    ctx_work_reg #(.W(EST_W)) u_est (
        .clk(clk), .rst(rst), .ld_i(ld_est_i && ld_gate), .ld_d_i(est_i),
        .rest_i(grant.pop_ok), .rest_d_i(pop_est), .q_o(est_o)
    );

    ctx_work_reg #(.W(N_COLS)) u_br (
        .clk(clk), .rst(rst), .ld_i(ld_br_i && ld_gate), .ld_d_i(br_i),
        .rest_i(grant.pop_ok), .rest_d_i(pop_br), .q_o(br_o)
    );

    ctx_work_reg #(.W(N_COLS)) u_res (
        .clk(clk), .rst(rst), .ld_i(ld_res_i && ld_gate), .ld_d_i(res_i),
        .rest_i(grant.pop_ok), .rest_d_i(pop_res), .q_o(res_o)
    );

    assert_restore_atomic_R4: assert property (@(posedge clk) disable iff (rst)
        grant.pop_ok |=> (col_o == $past(pop_col)) && (est_o == $past(pop_est))
                      && (br_o == $past(pop_br)) && (res_o == $past(pop_res)));

    assert_pop_blocks_load_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !grant.pop_ok) |=> $stable(col_o) && $stable(est_o)
                                  && $stable(br_o) && $stable(res_o) && $stable(row_o));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(empty_o && full_o));

endmodule

// File: tb/ctx_stack_bank_test.sv
module ctx_stack_bank_test;

    localparam int NR = 4;
    localparam int NC = 3;
    localparam int CW = 2;
    localparam int DP = 4;
    localparam int EW = NR * CW;
    localparam int LW = $clog2(DP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push = 1'b0, pop = 1'b0;
    logic ld_row = 1'b0, ld_col = 1'b0, ld_est = 1'b0, ld_br = 1'b0, ld_res = 1'b0;
    logic [NR-1:0] row_d = '0;
    logic [NC-1:0] col_d = '0, br_d = '0, res_d = '0;
    logic [EW-1:0] est_d = '0;
    logic [NR-1:0] row_q;
    logic [NC-1:0] col_q, br_q, res_q;
    logic [EW-1:0] est_q;
    logic [LW-1:0] level;
    logic empty, full, fault;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [NR-1:0] m_row = '0;
    logic [NC-1:0] m_col = '0, m_br = '0, m_res = '0;
    logic [EW-1:0] m_est = '0;
    logic          m_fault = 1'b0;
    int            m_lvl = 0;
    logic [NC-1:0] s_col [DP];
    logic [NC-1:0] s_br  [DP];
    logic [NC-1:0] s_res [DP];
    logic [EW-1:0] s_est [DP];

    always #2 clk = ~clk;

    ctx_stack_bank #(
        .N_ROWS(NR), .N_COLS(NC), .CNT_W(CW), .DEPTH(DP), .SHARE_ROW_SLOT(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .push_i(push), .pop_i(pop),
        .ld_row_i(ld_row), .row_i(row_d), .ld_col_i(ld_col), .col_i(col_d),
        .ld_est_i(ld_est), .est_i(est_d), .ld_br_i(ld_br), .br_i(br_d),
        .ld_res_i(ld_res), .res_i(res_d),
        .row_o(row_q), .col_o(col_q), .est_o(est_q), .br_o(br_q), .res_o(res_q),
        .level_o(level), .empty_o(empty), .full_o(full), .fault_o(fault)
    );

    function automatic logic [NR-1:0] rebuild(input logic [EW-1:0] e);
        logic [NR-1:0] r;
        for (int k = 0; k < NR; k++) r[k] = (e[k*CW +: CW] == '0);
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic restored);
        chk(restored ? "R5" : tag, "row", 32'(row_q), 32'(m_row));
        chk(tag, "col", 32'(col_q), 32'(m_col));
        chk(tag, "est", 32'(est_q), 32'(m_est));
        chk(tag, "br",  32'(br_q),  32'(m_br));
        chk(tag, "res", 32'(res_q), 32'(m_res));
        chk("R6", "level", 32'(level), 32'(m_lvl));
        chk("R6", "empty", 32'(empty), 32'(m_lvl == 0));
        chk("R6", "full",  32'(full),  32'(m_lvl == DP));
        chk(m_fault ? "R7" : "R8", "fault", 32'(fault), 32'(m_fault));
    endtask

    task automatic apply_loads(input logic [4:0] ld, input logic [NR-1:0] r,
                               input logic [NC-1:0] c, input logic [EW-1:0] e,
                               input logic [NC-1:0] b, input logic [NC-1:0] s);
        if (ld[0]) m_row = r;
        if (ld[1]) m_col = c;
        if (ld[2]) m_est = e;
        if (ld[3]) m_br  = b;
        if (ld[4]) m_res = s;
    endtask

    task automatic step(input logic p, input logic q, input logic [4:0] ld,
                        input logic [NR-1:0] r, input logic [NC-1:0] c,
                        input logic [EW-1:0] e, input logic [NC-1:0] b,
                        input logic [NC-1:0] s, input string tag);
        logic restored;
        restored = 1'b0;
        push = p; pop = q;
        {ld_res, ld_br, ld_est, ld_col, ld_row} = ld;
        row_d = r; col_d = c; est_d = e; br_d = b; res_d = s;
        if (p && !q) begin
            if (m_lvl < DP) begin
                s_col[m_lvl] = m_col; s_est[m_lvl] = m_est;
                s_br[m_lvl] = m_br;   s_res[m_lvl] = m_res;
                m_lvl++;
                m_fault = 1'b0;
            end else begin
                m_fault = 1'b1;
            end
            apply_loads(ld, r, c, e, b, s);
        end else if (q && !p) begin
            if (m_lvl > 0) begin
                m_lvl--;
                m_col = s_col[m_lvl]; m_est = s_est[m_lvl];
                m_br = s_br[m_lvl];   m_res = s_res[m_lvl];
                m_row = rebuild(m_est);
                m_fault = 1'b0;
                restored = 1'b1;
            end else begin
                m_fault = 1'b1;
            end
        end else if (p && q) begin
            m_fault = 1'b1;
        end else begin
            m_fault = 1'b0;
            apply_loads(ld, r, c, e, b, s);
        end
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
        {ld_res, ld_br, ld_est, ld_col, ld_row} = '0;
        check_all(tag, restored);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check_all("R1", 1'b0);

        // R2: sweep each working register alone
        for (int v = 0; v < 16; v++) step(0, 0, 5'b00001, NR'(v), '1, '1, '1, '1, "R2");
        for (int v = 0; v < 8; v++)  step(0, 0, 5'b00010, '1, NC'(v), '1, '1, '1, "R2");
        for (int v = 0; v < 256; v++) step(0, 0, 5'b00100, '1, '1, EW'(v), '1, '1, "R2");
        for (int v = 0; v < 8; v++)  step(0, 0, 5'b01000, '1, '1, '1, NC'(v), '1, "R2");
        for (int v = 0; v < 8; v++)  step(0, 0, 5'b10000, '1, '1, '1, '1, NC'(v), "R2");

        // R7: pop on empty with loads offered, then idle clears fault (R8)
        step(0, 1, 5'b11111, 4'h5, 3'h2, 8'hA5, 3'h6, 3'h1, "R7");
        step(0, 0, 5'b00000, '0, '0, '0, '0, '0, "R8");

        for (int sd = 0; sd < 8; sd++) begin
            // fill: each push also loads the next pattern (R3)
            for (int d = 0; d < DP; d++) begin
                step(1, 0, 5'b11111, NR'(sd + d), NC'(sd * 5 + d), EW'(sd * 53 + d * 29 + 7),
                     NC'(sd + d * 3), NC'(sd ^ d), "R3");
            end
            // R7: push when full, then clash
            step(1, 0, 5'b11111, '1, '1, 8'h3C, '1, '1, "R7");
            step(1, 1, 5'b11111, '0, '0, 8'h00, '0, '0, "R7");
            // drain with loads offered during every pop (R4), then one extra pop (R7)
            for (int d = 0; d <= DP; d++) begin
                step(0, 1, 5'b11111, 4'h9, 3'h5, EW'(d * 77), 3'h2, 3'h7,
                     (d == DP) ? "R7" : "R4");
            end
            // interleave: push one, reload, pop back
            step(1, 0, 5'b00100, '0, '0, EW'(sd * 17), '0, '0, "R3");
            step(0, 0, 5'b11011, NR'(sd), NC'(sd), '0, NC'(sd + 1), NC'(sd + 2), "R2");
            step(0, 1, 5'b00000, '0, '0, '0, '0, '0, "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule